// File: doc/BRIEF.md
# One-Shot Latency Spike Encoder

This block converts a row of pixel brightness words into time-coded spikes. A periodic, active-high period reset marks the start of every frame. While it is high, each pixel's brightness is captured and all spike lines are held low. Once it drops, a shared cycle counter measures the time since release. Each pixel raises its spike line once, after a delay that shrinks as the pixel gets brighter.

A pixel fires exactly once per period, and never again until the next period reset. Brightness is therefore carried by when a pixel fires, not by how often. A later stage can then compare the timing of spikes from two rows with simple coincidence logic. Each spike lasts a few cycles, so two pixels with nearly equal brightness produce spikes that partly overlap. If the next period reset arrives before a pixel has fired, that pixel stays silent for the rest of the period.

Top module: `lse_encoder`

## Requirements
- R1: While `rst_n` is low at a clock edge, every `spike` bit is 0 after that edge.
- R2: While `period_rst` is high at a clock edge, every `spike` bit is 0 after that edge.
- R3: Let E0 be the first rising edge at which `period_rst` is sampled low. A pixel with brightness L (8-bit unsigned) drives its spike high after edge E(255-L). Brightness 255 is therefore high in the first cycle after release.
- R4: Once raised, a spike stays high for exactly PULSE cycles (default 4), then returns low.
- R5: A pixel produces at most one spike per period. It does not fire again even when the counting phase runs far longer than 256 cycles.
- R6: The brightness word is captured at every edge at which `period_rst` is high, and the last captured value sets the delay. Changes to `pix_level` during the counting phase have no effect on that period's spikes.
- R7: When `period_rst` rises again, a pixel that has not fired stays silent for that period, and a spike still in progress is cut short at the next edge.
- R8: Pixels are independent. Pixel i takes its brightness from bits [i*8 +: 8] of `pix_level` and drives `spike[i]`. Equal brightness values give identical spike timing.
- R9: Brightness 0 fires after edge E255, which is the 256th cycle after release, with no wrap of the time base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| period_rst | input | 1 | Active-high periodic reset; its falling edge is the time reference |
| pix_level | input | NPIX*IW (64) | Packed brightness words, pixel i at bits [i*IW +: IW] |
| spike | output | NPIX (8) | One latency-coded spike line per pixel |

## Verification
A directed frame covers the extreme brightness values 255, 254, 1 and 0 next to mid-range values, which pins down the off-by-one of the release reference and the far end of the counter. A frame of identical values separates true per-pixel independence from any cross-pixel coupling. A frame whose counting phase is cut short, with one pixel caught mid-pulse, separates silence and truncation from late firing. Random frames are also run: some with the brightness bus scrambled during counting, some with very long counting phases, and some plain. These show whether the captured value is really held, and whether the saturating time base prevents any second spike.

// File: rtl/lse_pkg.sv
// Package: shared types for the latency spike encoder.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package lse_pkg;

    // Per-pixel firing phase within one period.
    typedef enum logic [1:0] {
        NS_WAIT = 2'd0,   // armed, waiting for its latency to elapse
        NS_FIRE = 2'd1,   // spike line high
        NS_DONE = 2'd2    // fired this period, silent until period reset
    } nstate_t;

endpackage

// File: rtl/lse_timebase.sv
// Module: shared time base counting clock edges since period-reset release.
// Assumes: period_rst is synchronous to clk. The count saturates at its
// maximum, so it never wraps inside one long period.
module lse_timebase #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_rst,
    output logic [CW-1:0] elapsed
);
    localparam logic [CW-1:0] CMAX = '1;

    // Clear while the period reset is high; otherwise count up, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n || period_rst) begin
            elapsed <= '0;
        end else if (elapsed != CMAX) begin
            elapsed <= elapsed + 1'b1;
        end
    end

    // R3
    tb_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_rst |=> (elapsed == '0));

    // R3
    tb_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_rst && elapsed != CMAX) |=> (elapsed == $past(elapsed) + 1'b1));

    // R5
    tb_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_rst && elapsed == CMAX) |=> (elapsed == CMAX));

endmodule

// File: rtl/lse_neuron.sv
// Module: one-shot latency neuron for a single pixel.
// Captures its brightness while the period reset is high, fires once when
// the shared time base reaches (max - brightness), and holds the spike for
// PULSE cycles.
// Assumes: elapsed comes from lse_timebase, is cleared by the same period
// reset and is at least one bit wider than the brightness word.
module lse_neuron
    import lse_pkg::*;
#(
    parameter int IW    = 8,
    parameter int CW    = 9,
    parameter int PULSE = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          period_rst,
    input  logic [IW-1:0] level,
    input  logic [CW-1:0] elapsed,
    output logic          spike
);
    localparam int            PW   = $clog2(PULSE + 1);
    localparam logic [IW-1:0] LMAX = '1;

    logic [IW-1:0] thr;
    logic [PW-1:0] pcnt;
    nstate_t       st;

    // Capture the delay, run the fire/pulse/done sequence once per period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            thr  <= '0;
            pcnt <= '0;
            st   <= NS_WAIT;
        end else if (period_rst) begin
            thr  <= LMAX - level;
            pcnt <= '0;
            st   <= NS_WAIT;
        end else begin
            unique case (st)
                NS_WAIT: begin
                    if (elapsed == CW'(thr)) begin
                        st   <= NS_FIRE;
                        pcnt <= PW'(PULSE);
                    end
                end
                NS_FIRE: begin
                    if (pcnt == PW'(1)) begin
                        st   <= NS_DONE;
                        pcnt <= '0;
                    end else begin
                        pcnt <= pcnt - 1'b1;
                    end
                end
                default: st <= NS_DONE;
            endcase
        end
    end

    // Spike line is high only during the pulse phase.
    always_comb spike = (st == NS_FIRE);

    // R2
    nr_prst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_rst |=> !spike);

    // R3
    nr_fire_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spike) |-> (elapsed == CW'(thr) + 1'b1));

    // R4
    nr_pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spike && !period_rst && pcnt != PW'(1)) |=> spike);

    // R5
    nr_one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!spike && $past(spike) && !period_rst) |=> !spike);

    // R6
    nr_hold_thr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !period_rst |=> (thr == $past(thr)));

endmodule

// File: rtl/lse_encoder.sv
// Module: top of the one-shot latency spike encoder.
// One shared time base feeds NPIX independent one-shot neurons.
// Assumes: all inputs are synchronous to clk. Pixel i uses bits
// [i*IW +: IW] of pix_level and drives spike[i].
module lse_encoder #(
    parameter int NPIX  = 8,
    parameter int IW    = 8,
    parameter int PULSE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               period_rst,
    input  logic [NPIX*IW-1:0] pix_level,
    output logic [NPIX-1:0]    spike
);
    localparam int CW = IW + 1;

    logic [CW-1:0] elapsed;

    // Shared time reference for all pixels.
    lse_timebase #(.CW(CW)) u_tb (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_rst (period_rst),
        .elapsed    (elapsed)
    );

    // One neuron per pixel.
    for (genvar gi = 0; gi < NPIX; gi++) begin : g_pix
        lse_neuron #(.IW(IW), .CW(CW), .PULSE(PULSE)) u_nr (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_rst (period_rst),
            .level      (pix_level[gi*IW +: IW]),
            .elapsed    (elapsed),
            .spike      (spike[gi])
        );
    end

    // R1
    top_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (spike == '0));

    // R2
    top_prst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        period_rst |=> (spike == '0));

endmodule

// File: tb/sim_lse_encoder.sv
module sim_lse_encoder;
    localparam int NPIX  = 8;
    localparam int IW    = 8;
    localparam int PULSE = 4;
    localparam int LMAX  = 255;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               period_rst = 1'b1;
    logic [NPIX*IW-1:0] pix_level = '0;
    logic [NPIX-1:0]    spike;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;
    int lv [NPIX];

    always #5 clk = ~clk;

    lse_encoder #(.NPIX(NPIX), .IW(IW), .PULSE(PULSE)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .period_rst (period_rst),
        .pix_level  (pix_level),
        .spike      (spike)
    );

    // Expected spike level in cycle k after release (k edges sampled low).
    function automatic logic exp_spike(int d, int k);
        return (k - 1 >= d) && (k - 1 <= d + PULSE - 1);
    endfunction

    task automatic chk(string tag, int pix, logic act, logic expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s pixel %0d t=%0t actual=%b expected=%b", tag, pix, $time, act, expv);
        end
    endtask

    task automatic drive_levels();
        for (int i = 0; i < NPIX; i++) pix_level[i*IW +: IW] = IW'(lv[i]);
    endtask

    // One period: reset high for a few cycles, then L counting cycles.
    task automatic run_period(int L, bit scramble, string ptag);
        int d [NPIX];
        string tag;
        logic e;
        period_rst = 1'b1;
        drive_levels();
        for (int i = 0; i < NPIX; i++) d[i] = LMAX - lv[i];
        repeat (3) @(negedge clk);
        for (int i = 0; i < NPIX; i++) chk("R2", i, spike[i], 1'b0);
        period_rst = 1'b0;
        for (int k = 1; k <= L; k++) begin
            @(negedge clk);
            for (int i = 0; i < NPIX; i++) begin
                e = exp_spike(d[i], k);
                if (ptag.len() != 0)      tag = ptag;
                else if (k - 1 == d[i])   tag = "R3";
                else if (e)               tag = "R4";
                else if (k - 1 > d[i])    tag = "R5";
                else                      tag = "R3";
                chk(tag, i, spike[i], e);
            end
            if (scramble) pix_level = {$urandom, $urandom};
        end
        period_rst = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NPIX; i++) chk("R7", i, spike[i], 1'b0);
    endtask

    initial begin
        void'($urandom(32'd4711));
        pix_level = {$urandom, $urandom};
        repeat (3) @(negedge clk);
        // R1: reset state
        for (int i = 0; i < NPIX; i++) chk("R1", i, spike[i], 1'b0);
        rst_n = 1'b1;

        // R3 / R9 extremes and mid values
        lv = '{255, 254, 0, 128, 1, 200, 127, 100};
        run_period(270, 1'b0, "");
        // R9 dedicated: brightness 0 at the boundary
        lv = '{0, 0, 255, 0, 0, 1, 0, 0};
        run_period(262, 1'b0, "R9");
        // R8 identical values
        for (int i = 0; i < NPIX; i++) lv[i] = 50;
        run_period(220, 1'b0, "R8");
        // R7 truncated period: pixel 0 cut mid-pulse, pixel 1 never fires
        lv = '{157, 10, 240, 200, 180, 250, 3, 159};
        run_period(100, 1'b0, "R7");
        // R6 scrambled bus during counting
        for (int i = 0; i < NPIX; i++) lv[i] = int'($urandom_range(0, 255));
        run_period(270, 1'b1, "R6");
        // R5 very long counting phase, no second spike
        for (int i = 0; i < NPIX; i++) lv[i] = int'($urandom_range(0, 255));
        lv[3] = 0;
        run_period(600, 1'b0, "R5");
        // random frames
        for (int p = 0; p < 4; p++) begin
            for (int i = 0; i < NPIX; i++) lv[i] = int'($urandom_range(0, 255));
            run_period(int'($urandom_range(150, 280)), p[0], "");
        end
        // R1: reset in the middle of counting clears the outputs
        lv = '{255, 255, 255, 255, 255, 255, 255, 255};
        drive_levels();
        repeat (2) @(negedge clk);
        period_rst = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        for (int i = 0; i < NPIX; i++) chk("R1", i, spike[i], 1'b0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule